// File: doc/BRIEF.md
# Periodic Countdown Timer with Interrupt

This block is a 16-bit down-counter that produces a periodic interrupt. A prescaler divides the system clock into a one-cycle tick, and `TICK_DIV` sets its period. The default of 2500 gives a 100 µs tick from a 25 MHz clock. While the timer runs, each tick lowers the count by one. When the count steps onto zero, a sticky status flag is set. The tick after that wraps the count to all ones, and counting goes on. The preload value is not reused.

Software reaches the block through a single-cycle synchronous register port. One word holds the preload value and the run bit. A read-only word shows the live count. A third word holds the status flag, which is cleared by writing one to it, and the interrupt mask. The `irq` output is the status flag gated by the mask.

Top module: `tick_timer`

## Requirements
- R1: After reset, the count reads 0xFFFF, the config word reads 0x0000_FFFF (preload all ones, run bit clear), the status word reads 0, and `irq` is low.
- R2: Any write to the config word (offset 0x0, preload in bits 15:0, run in bit 31) replaces the live count with the written preload field on the next cycle. This holds whether the timer is running or not. While the run bit is clear, the count holds.
- R3: While running, the count drops by one every `TICK_DIV` cycles. The first drop comes `TICK_DIV` cycles after the config write.
- R4: A tick that finds the count at 0x0000 makes it 0xFFFF, not the preload value.
- R5: The status flag (status word bit 0) is set on the tick that moves the count from 0x0001 to 0x0000.
- R6: The status flag stays set until a status-word write with bit 0 at one. A write with bit 0 at zero leaves it set. If a clearing write and an expiry land in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when the status flag and the mask (status word bit 1, read/write) are both one.
- R8: A config write that turns the run bit from one to zero leaves the stored preload at 0xFFFF. Counting stops.
- R9: The count word (offset 0x4) is read-only, and writes to it have no effect. Offsets other than 0x0, 0x4 and 0x8 read as zero. Unused bits read as zero.
- R10: A config write while running restarts the prescaler, so the first period after it is full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, status gated by mask |

## Verification
The bench builds the block with `TICK_DIV` set to 4. A tick then comes every four clocks, so a short run covers several decrements, the expiry onto zero, the wrap to all ones and restarts mid-period. With this short period, a status clear can also be placed on the exact edge of an expiry, which tests the set-over-clear priority. The 2500 default is only elaborated. Its period changes no decision other than the prescaler terminal value.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int CNT_W   = 16;
    localparam int RUN_BIT = 31;
    localparam int STS_BIT = 0;
    localparam int MSK_BIT = 1;

    localparam logic [ADDR_W-1:0] OFS_CFG = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] OFS_CNT = ADDR_W'(4'h4);
    localparam logic [ADDR_W-1:0] OFS_STS = ADDR_W'(4'h8);

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_ONES = '1;

    typedef enum logic [1:0] {
        SEL_CFG,
        SEL_CNT,
        SEL_STS,
        SEL_NONE
    } rsel_t;

    // One decoded register write, valid for a single cycle
    typedef struct packed {
        logic cfg_wr;
        logic sts_wr;
        cnt_t new_preload;
        logic new_run;
        logic sts_clr;
        logic new_mask;
    } wcmd_t;

    function automatic rsel_t addr_sel(input logic [ADDR_W-1:0] a);
        rsel_t s;
        case (a)
            OFS_CFG: s = SEL_CFG;
            OFS_CNT: s = SEL_CNT;
            OFS_STS: s = SEL_STS;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Next value on a tick: wrap from zero to all ones
    function automatic cnt_t step_down(input cnt_t c);
        return (c == '0) ? CNT_ONES : cnt_t'(c - cnt_t'(1));
    endfunction

    // True when the coming tick lands the count on zero
    function automatic logic lands_on_zero(input cnt_t c);
        return c == cnt_t'(1);
    endfunction

endpackage

// File: rtl/ptimer_bus.sv
module ptimer_bus
    import ptimer_pkg::*;
(
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  cnt_t              preload,
    input  logic              run,
    input  cnt_t              count,
    input  logic              status,
    input  logic              mask,
    output wcmd_t             cmd,
    output logic [DATA_W-1:0] bus_rdata
);

    rsel_t sel;

    always_comb begin
        sel = addr_sel(bus_addr);
    end

    always_comb begin
        cmd             = '0;
        cmd.cfg_wr      = bus_we && (sel == SEL_CFG);
        cmd.sts_wr      = bus_we && (sel == SEL_STS);
        cmd.new_preload = bus_wdata[CNT_W-1:0];
        cmd.new_run     = bus_wdata[RUN_BIT];
        cmd.sts_clr     = bus_wdata[STS_BIT];
        cmd.new_mask    = bus_wdata[MSK_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CFG: begin
                bus_rdata[CNT_W-1:0] = preload;
                bus_rdata[RUN_BIT]   = run;
            end
            SEL_CNT: bus_rdata[CNT_W-1:0] = count;
            SEL_STS: begin
                bus_rdata[STS_BIT] = status;
                bus_rdata[MSK_BIT] = mask;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
    parameter int TICK_DIV = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    generate
        if (TICK_DIV == 1) begin : g_every_cycle
            assign tick = run && !restart;
        end else begin : g_divider
            logic [PW-1:0] phase;

            always_ff @(posedge clk) begin
                if (rst || !run || restart) begin
                    phase <= '0;
                end else if (phase == LAST) begin
                    phase <= '0;
                end else begin
                    phase <= phase + PW'(1);
                end
            end

            assign tick = run && !restart && (phase == LAST);
        end
    endgenerate

endmodule

// File: rtl/ptimer_core.sv
module ptimer_core
    import ptimer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wcmd_t cmd,
    input  logic  tick,
    output cnt_t  count,
    output cnt_t  preload,
    output logic  run,
    output logic  expire
);

    logic stopping;

    always_comb begin
        stopping = cmd.cfg_wr && run && !cmd.new_run;
        expire   = run && tick && !cmd.cfg_wr && lands_on_zero(count);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= CNT_ONES;
            preload <= CNT_ONES;
            run     <= 1'b0;
        end else if (cmd.cfg_wr) begin
            run     <= cmd.new_run;
            count   <= cmd.new_preload;
            preload <= stopping ? CNT_ONES : cmd.new_preload;
        end else if (run && tick) begin
            count <= step_down(count);
        end
    end

endmodule

// File: rtl/ptimer_irq.sv
module ptimer_irq
    import ptimer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wcmd_t cmd,
    input  logic  expire,
    output logic  status,
    output logic  mask,
    output logic  irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (expire) begin
            status <= 1'b1;
        end else if (cmd.sts_wr && cmd.sts_clr) begin
            status <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= 1'b0;
        end else if (cmd.sts_wr) begin
            mask <= cmd.new_mask;
        end
    end

    assign irq = status && mask;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import ptimer_pkg::*;
#(
    parameter int TICK_DIV = 2500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    wcmd_t cmd;
    cnt_t  count;
    cnt_t  preload;
    logic  run;
    logic  tick;
    logic  expire;
    logic  status;
    logic  mask;

    ptimer_bus u_bus (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .preload   (preload),
        .run       (run),
        .count     (count),
        .status    (status),
        .mask      (mask),
        .cmd       (cmd),
        .bus_rdata (bus_rdata)
    );

    ptimer_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (cmd.cfg_wr),
        .tick    (tick)
    );

    ptimer_core u_core (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .tick    (tick),
        .count   (count),
        .preload (preload),
        .run     (run),
        .expire  (expire)
    );

    ptimer_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .expire (expire),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import ptimer_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input wcmd_t cmd,
    input logic  tick,
    input logic  run,
    input cnt_t  count,
    input cnt_t  preload,
    input logic  status,
    input logic  mask,
    input logic  irq
);

    a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
        cmd.cfg_wr |=> count == $past(cmd.new_preload));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!run && !cmd.cfg_wr) |=> $stable(count));

    a_r4_wrap_ones: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count == '0) |=> count == CNT_ONES);

    a_r5_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !cmd.cfg_wr && count == cnt_t'(1)) |=> (status && count == '0));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (status && !(cmd.sts_wr && cmd.sts_clr)) |=> status);

    a_r7_irq_on: assert property (@(posedge clk) disable iff (rst)
        (status && mask) |-> irq);

    a_r7_irq_off: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status && mask));

    a_r8_stop_ones: assert property (@(posedge clk) disable iff (rst)
        (cmd.cfg_wr && run && !cmd.new_run) |=> (preload == CNT_ONES && !run));

endmodule

bind tick_timer tick_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .tick    (tick),
    .run     (run),
    .count   (count),
    .preload (preload),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tick_timer #(.TICK_DIV(DIV)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [7:0]  idle;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // idle cycles come first, then the write or the read check
    localparam vec_t VECS [25] = '{
        '{1'b0, 4'h4, 32'h0,         8'd0, 32'h0000_FFFF, 8'd1},  // R1 count
        '{1'b0, 4'h0, 32'h0,         8'd0, 32'h0000_FFFF, 8'd1},  // R1 config
        '{1'b0, 4'h8, 32'h0,         8'd0, 32'h0,         8'd1},  // R1 status
        '{1'b1, 4'h4, 32'h1234,      8'd0, 32'h0,         8'd9},
        '{1'b0, 4'h4, 32'h0,         8'd0, 32'h0000_FFFF, 8'd9},  // R9 read-only
        '{1'b1, 4'h0, 32'h0000_0005, 8'd0, 32'h0,         8'd2},
        '{1'b0, 4'h4, 32'h0,         8'd0, 32'h5,         8'd2},  // R2 load idle
        '{1'b0, 4'h4, 32'h0,         8'd8, 32'h5,         8'd2},  // R2 hold
        '{1'b1, 4'h8, 32'h2,         8'd0, 32'h0,         8'd7},
        '{1'b1, 4'h0, 32'h8000_0002, 8'd0, 32'h0,         8'd3},
        '{1'b0, 4'h4, 32'h0,         8'd3, 32'h2,         8'd3},  // R3 full period
        '{1'b0, 4'h4, 32'h0,         8'd1, 32'h1,         8'd3},  // R3 first step
        '{1'b0, 4'h8, 32'h0,         8'd0, 32'h2,         8'd5},  // R5 not yet
        '{1'b0, 4'h4, 32'h0,         8'd4, 32'h0,         8'd3},  // R3 at zero
        '{1'b0, 4'h8, 32'h0,         8'd0, 32'h3,         8'd5},  // R5 flag set
        '{1'b0, 4'h4, 32'h0,         8'd4, 32'h0000_FFFF, 8'd4},  // R4 wrap
        '{1'b1, 4'h8, 32'h2,         8'd0, 32'h0,         8'd6},
        '{1'b0, 4'h8, 32'h0,         8'd0, 32'h3,         8'd6},  // R6 zero write
        '{1'b1, 4'h8, 32'h3,         8'd0, 32'h0,         8'd6},
        '{1'b0, 4'h8, 32'h0,         8'd0, 32'h2,         8'd6},  // R6 cleared
        '{1'b0, 4'h0, 32'h0,         8'd0, 32'h8000_0002, 8'd9},  // R9 config read
        '{1'b1, 4'h0, 32'h0000_0007, 8'd0, 32'h0,         8'd8},
        '{1'b0, 4'h0, 32'h0,         8'd0, 32'h0000_FFFF, 8'd8},  // R8 preload ones
        '{1'b0, 4'h4, 32'h0,         8'd8, 32'h7,         8'd8},  // R8 stopped
        '{1'b0, 4'hC, 32'h0,         8'd0, 32'h0,         8'd9}   // R9 undefined
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst       = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        @(negedge clk);
        idle(3);
        rst = 1'b0;
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < 25; i++) begin
            idle(int'(VECS[i].idle));
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].data);
            end else begin
                rd($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].addr, VECS[i].exp);
            end
        end

        // R7: flag set with mask clear keeps irq low, mask raises it
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h8000_0001);
        idle(4);
        check("R7 masked", {31'b0, irq}, 32'h0);
        rd("R5 flag unmasked read", 4'h8, 32'h1);
        wr(4'h8, 32'h2);
        check("R7 unmasked", {31'b0, irq}, 32'h1);

        // R6: clear lands on the same edge as an expiry, set wins
        wr(4'h8, 32'h3);
        check("R7 after clear", {31'b0, irq}, 32'h0);
        wr(4'h0, 32'h8000_0001);
        idle(DIV - 1);
        wr(4'h8, 32'h3);
        rd("R6 set wins", 4'h8, 32'h3);
        check("R6 irq kept", {31'b0, irq}, 32'h1);
        rd("R5 count zero", 4'h4, 32'h0);

        // R10: mid-period rewrite restarts the prescaler
        idle(2);
        wr(4'h0, 32'h8000_0009);
        idle(DIV - 1);
        rd("R10 no early step", 4'h4, 32'h9);
        idle(1);
        rd("R10 full period", 4'h4, 32'h8);

        // R1: reset mid-run
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        rd("R1 count after rst", 4'h4, 32'h0000_FFFF);
        rd("R1 config after rst", 4'h0, 32'h0000_FFFF);
        rd("R1 status after rst", 4'h8, 32'h0);
        check("R1 irq after rst", {31'b0, irq}, 32'h0);

        finish_run();
    end

endmodule